// File: doc/BRIEF.md
# Program Counter Trace Serializer

This debug block sits next to a soft processor core. Whenever the core's program counter moves to a new value, the block sends that value to a narrow test port so that an external logic analyser can record it. It does not buffer records. Instead, it withholds the core's clock enable while a record is being sent and restores it once the last chunk has left.

Each record splits the counter into equal chunks, sent most significant chunk first. Every chunk occupies two phases. In the first phase the chunk is driven with the strobe low. In the second phase the strobe is high and the chunk is held. A capture tool therefore takes one chunk on each rising strobe edge. No record is produced for counter values inside a reserved high I/O window, so code that moves data through that window runs at full speed. A trace-enable input switches the whole mechanism off.

Top module: `pc_trace_serializer`

## Requirements
- R1: When `cpu_ce_in` is high and `pc_in` differs from the last counter value seen, a record of the new value starts on the next clock edge.
- R2: While a record is being sent, `cpu_ce_out` is low. It stays low for exactly 2 x (PC_W/CHUNK_W) x HOLD_CYCLES cycles per record and then follows `cpu_ce_in` again.
- R3: A record carries PC_W/CHUNK_W chunks. The first chunk is the top CHUNK_W bits of the counter and the last chunk is the bottom CHUNK_W bits.
- R4: Each chunk first spends HOLD_CYCLES cycles with `tp_strobe` low, then HOLD_CYCLES cycles with `tp_strobe` high. A receiver takes one chunk on each rising strobe edge.
- R5: `tp_data` is stable for at least HOLD_CYCLES cycles before each rising strobe edge and stays unchanged while the strobe is high.
- R6: A counter value at or above IO_BASE produces no record and no stall. The value IO_BASE-1 is still traced.
- R7: If the counter changes while a record is being sent, the new value is held and sent immediately after the current record. The stall covers both records without a gap.
- R8: A counter change is only compared while `cpu_ce_in` is high. An unchanged counter never produces a record.
- R9: With `trace_en` low, `cpu_ce_out` equals `cpu_ce_in`, the strobe stays low and no record is sent. The last-seen value keeps following `pc_in`, so re-enabling does not emit a stale record.
- R10: After reset, `tp_strobe` is low, `tp_data` is zero and `cpu_ce_out` follows `cpu_ce_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing on when high |
| cpu_ce_in | input | 1 | Clock enable requested for the core |
| pc_in | input | PC_W | Current program counter of the core |
| cpu_ce_out | output | 1 | Gated clock enable to the core |
| tp_data | output | CHUNK_W | Test port data chunk |
| tp_strobe | output | 1 | Test port strobe, rising edge qualifies a chunk |

## Verification
The bench builds the block with a 12-bit counter, 3-bit chunks, HOLD_CYCLES of 2 and IO_BASE at 0xF00. With these values every counter value can be swept in turn, including both sides of the window boundary. The bench reassembles every record from the test port and compares it with the value it drove. It also measures the length of each stall, checks the hold time before each strobe edge, and covers back-to-back records, a low clock-enable request and the tracing switch.

// File: rtl/pc_trace_serializer.sv
module pc_trace_serializer #(
  parameter int PC_W = 24,
  parameter int CHUNK_W = 6,
  parameter int HOLD_CYCLES = 1,
  parameter logic [PC_W-1:0] IO_BASE = 24'hF00000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trace_en,
  input  logic               cpu_ce_in,
  input  logic [PC_W-1:0]    pc_in,
  output logic               cpu_ce_out,
  output logic [CHUNK_W-1:0] tp_data,
  output logic               tp_strobe
);
  localparam int NCH = PC_W / CHUNK_W;
  localparam int NPH = 2 * NCH;
  localparam int PHW = $clog2(NPH);
  localparam int HW  = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

  logic            busy, pend_v;
  logic [PHW-1:0]  ph;
  logic [HW-1:0]   sub;
  logic [PC_W-1:0] shreg, last_pc, pend_pc;

  wire changed   = cpu_ce_in && (pc_in != last_pc);
  wire traced    = changed && (pc_in < IO_BASE);
  wire phase_end = (sub == HW'(HOLD_CYCLES - 1));
  wire rec_end   = phase_end && (ph == PHW'(NPH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pend_v <= 1'b0; ph <= '0; sub <= '0;
      shreg <= '0; last_pc <= '0; pend_pc <= '0;
    end else if (!trace_en) begin
      busy <= 1'b0; pend_v <= 1'b0; ph <= '0; sub <= '0;
      last_pc <= pc_in;
    end else begin
      if (changed) last_pc <= pc_in;
      if (busy) begin
        if (phase_end) begin
          sub <= '0;
          ph  <= rec_end ? '0 : ph + 1'b1;
          if (ph[0]) shreg <= shreg << CHUNK_W;
        end else begin
          sub <= sub + 1'b1;
        end
        if (traced && !(rec_end && !pend_v)) begin
          pend_pc <= pc_in;
          pend_v  <= 1'b1;
        end
        if (rec_end) begin
          if (pend_v) begin
            shreg <= pend_pc;
            if (!traced) pend_v <= 1'b0;
          end else if (traced) begin
            shreg <= pc_in;
          end else begin
            busy <= 1'b0;
          end
        end
      end else if (traced) begin
        busy <= 1'b1; shreg <= pc_in; ph <= '0; sub <= '0;
      end
    end
  end

  wire sending = trace_en && busy;
  assign cpu_ce_out = cpu_ce_in && !sending;
  assign tp_strobe  = sending && ph[0];
  assign tp_data    = sending ? shreg[PC_W-1 -: CHUNK_W] : '0;
endmodule

// File: rtl/pc_trace_serializer_chk.sv
module pc_trace_serializer_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          cpu_ce_in,
  input logic          cpu_ce_out,
  input logic [CW-1:0] tp_data,
  input logic          tp_strobe
);
  assert_stall_while_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tp_strobe |-> !cpu_ce_out);
  assert_data_held_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_strobe) |-> $stable(tp_data));
  assert_data_held_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_strobe && $past(tp_strobe)) |-> $stable(tp_data));
  assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |-> (cpu_ce_out == cpu_ce_in && !tp_strobe));
  assert_no_spurious_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce_in |-> !cpu_ce_out);
endmodule

bind pc_trace_serializer pc_trace_serializer_chk #(.CW(CHUNK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cpu_ce_in(cpu_ce_in),
  .cpu_ce_out(cpu_ce_out), .tp_data(tp_data), .tp_strobe(tp_strobe)
);

// File: tb/sim_pc_trace_serializer.sv
module sim_pc_trace_serializer;
  localparam int PW = 12, CW = 3, HOLD = 2;
  localparam int NCH = PW / CW;
  localparam int STALL = 2 * NCH * HOLD;
  localparam logic [PW-1:0] BASE = 12'hF00;

  logic clk = 0, rst_n = 0, trace_en = 1, cpu_ce_in = 1;
  logic [PW-1:0] pc_in = '0;
  logic cpu_ce_out, tp_strobe;
  logic [CW-1:0] tp_data;

  pc_trace_serializer #(.PC_W(PW), .CHUNK_W(CW), .HOLD_CYCLES(HOLD), .IO_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .cpu_ce_in(cpu_ce_in),
    .pc_in(pc_in), .cpu_ce_out(cpu_ce_out), .tp_data(tp_data), .tp_strobe(tp_strobe));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // test-port receiver and stall monitor, sampled at the falling edge
  logic prev_stb = 0;
  logic [CW-1:0] prev_data = '0;
  logic [PW-1:0] rx = '0, rec_last = '0, rec_prev = '0;
  int rx_cnt = 0, rec_cnt = 0, stable_cnt = 0, run = 0, last_run = 0, stall_total = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      stable_cnt = (tp_data == prev_data) ? stable_cnt + 1 : 1;
      if (tp_strobe && !prev_stb) begin
        check(stable_cnt >= HOLD + 1, "R5 setup", stable_cnt, HOLD + 1);
        rx = {rx[PW-CW-1:0], tp_data};
        rx_cnt++;
        if (rx_cnt == NCH) begin
          rec_prev = rec_last; rec_last = rx; rec_cnt++; rx_cnt = 0;
        end
      end
      if (tp_strobe && prev_stb)
        check(tp_data == prev_data, "R5 hold", tp_data, prev_data);
      if (trace_en && cpu_ce_in && !cpu_ce_out) begin
        run++; stall_total++;
      end else if (run != 0) begin
        last_run = run; run = 0;
      end
      prev_stb = tp_strobe;
      prev_data = tp_data;
    end
  end

  task automatic trace_one(input logic [PW-1:0] v);
    int r0, s0;
    bit exp_rec;
    exp_rec = (v < BASE);
    @(negedge clk); pc_in = v;
    r0 = rec_cnt; s0 = stall_total;
    repeat (STALL + 3) @(negedge clk);
    if (exp_rec) begin
      // R1 R3: one record carrying v, top chunk first
      check(rec_cnt == r0 + 1 && rec_last == v, "R1 R3 record", rec_last, v);
      // R2: exact stall length, then released
      check(stall_total - s0 == STALL && cpu_ce_out, "R2 stall", stall_total - s0, STALL);
    end else begin
      // R6: nothing for the reserved window
      check(rec_cnt == r0 && stall_total == s0, "R6 window", rec_cnt - r0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!tp_strobe && tp_data == '0, "R10 outputs", {tp_strobe, tp_data}, 0);
    check(cpu_ce_out == 1'b1, "R10 ce", cpu_ce_out, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R6: sweep every counter value
    for (int v = 1; v < (1 << PW); v++) trace_one(PW'(v));
    check(rec_cnt == int'(BASE) - 1, "R6 count", rec_cnt, int'(BASE) - 1);

    // R8: unchanged counter gives nothing
    begin
      int r0;
      r0 = rec_cnt;
      repeat (20) @(negedge clk);
      check(rec_cnt == r0, "R8 steady", rec_cnt - r0, 0);
    end

    // R7: change during a record is sent right after it
    begin
      int r0;
      @(negedge clk); pc_in = 12'h123; r0 = rec_cnt;
      @(negedge clk); pc_in = 12'h456;
      repeat (2 * STALL + 4) @(negedge clk);
      check(rec_cnt == r0 + 2, "R7 count", rec_cnt - r0, 2);
      check(rec_prev == 12'h123, "R7 first", rec_prev, 12'h123);
      check(rec_last == 12'h456, "R7 second", rec_last, 12'h456);
      check(last_run == 2 * STALL, "R7 no gap", last_run, 2 * STALL);
    end

    // R8: no comparison while the enable request is low
    begin
      int r0;
      @(negedge clk); cpu_ce_in = 0; pc_in = 12'h0AB; r0 = rec_cnt;
      repeat (6) @(negedge clk);
      check(rec_cnt == r0 && !cpu_ce_out && !tp_strobe, "R8 ce low", rec_cnt - r0, 0);
      cpu_ce_in = 1;
      repeat (STALL + 3) @(negedge clk);
      check(rec_cnt == r0 + 1 && rec_last == 12'h0AB, "R8 ce high", rec_last, 12'h0AB);
    end

    // R9: tracing off
    begin
      int r0;
      @(negedge clk); trace_en = 0; r0 = rec_cnt;
      cpu_ce_in = 0; #1;
      check(cpu_ce_out == 0, "R9 pass low", cpu_ce_out, 0);
      @(negedge clk); cpu_ce_in = 1; #1;
      check(cpu_ce_out == 1, "R9 pass high", cpu_ce_out, 1);
      @(negedge clk); pc_in = 12'h300;
      repeat (STALL + 3) begin
        @(negedge clk);
        check(!tp_strobe && cpu_ce_out, "R9 quiet", tp_strobe, 0);
      end
      trace_en = 1;
      repeat (STALL + 3) @(negedge clk);
      check(rec_cnt == r0, "R9 no stale", rec_cnt - r0, 0);
      trace_one(12'h301);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule